// File: doc/BRIEF.md
# DMA Channel Control and Status Bank

This block holds the shared control and status state of a multi-channel DMA controller. It sits on a simple 32-bit register bus. A write is a single cycle with `reg_wen` high. A read is combinational from `reg_addr`. For every channel it keeps these mask bits:

- channel enable
- interrupt enable
- error flag
- completion flag A
- completion flag B

Bit n of each mask belongs to channel n.

The enable masks each have a set address and a clear address. The three flag masks are cleared by writing ones to them. The channel engines report four things back to the bank:

- an active mask
- a busy mask
- error events
- completion events for flags A and B

A global enable bit gates the whole controller. A summary word collects the interrupt state, and a single level interrupt line carries it to the interrupt controller.

Writes to three command addresses produce one-cycle pulses toward the selected channels. These pulses mark a descriptor valid, set a channel trigger or abort a channel. The data movers, the descriptor memory and the bus master sit outside this block.

Top module: `dmac_ctrl_bank`

## Requirements
- R1: With the default of 16 channels, bit n of every per-channel register, port and pulse refers to channel n.
- R2: Writing ones to address 2 sets channel-enable bits, and writing ones to address 3 clears them. Reading address 2 returns the enable mask. While the global enable is on, `ch_enable` equals that mask from the cycle after the write.
- R3: Bit 0 of address 0 is the global enable and reads back. While it is 0, `ch_enable` is all zero and command writes produce no pulse. The enable mask itself is kept.
- R4: Writing ones to address 7 sets interrupt-enable bits, and writing ones to address 8 clears them. Reading address 7 returns that mask. A channel whose interrupt enable is 0 adds nothing to the summary word or to `irq`.
- R5: The error flags (address 6), A flags (address 9) and B flags (address 10) are set by a one-cycle event on `ch_err_evt`, `ch_inta_evt` and `ch_intb_evt`. Writing a 1 to a bit of the flag's address clears that bit. Writing a 0 leaves it unchanged.
- R6: When a clearing write and a new event hit the same flag bit in the same cycle, the flag ends up set.
- R7: Address 1 reads the summary word. Bit 1 is high when some channel has flag A or B set and its interrupt enabled. Bit 2 is high when some channel has its error flag set and its interrupt enabled. All other bits read 0.
- R8: Address 4 reads `ch_active` and address 5 reads `ch_busy`. Writes to addresses 1, 4 and 5 have no effect.
- R9: Writing ones to address 11 (valid), 12 (trigger) or 13 (abort) drives those bits high on `ch_valid_pulse`, `ch_trig_pulse` or `ch_abort_pulse` for exactly the one cycle after the write.
- R10: The write-only addresses (3, 8, 11, 12, 13) and the unused addresses 14 and 15 read as zero.
- R11: `irq` is high exactly when summary bit 1 or bit 2 is high.
- R12: After reset every mask, flag, pulse and the global enable is zero, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wen | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 4 | Word address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| ch_enable | output | 16 | Per-channel enable to the engines |
| ch_valid_pulse | output | 16 | One-cycle descriptor-valid pulses |
| ch_trig_pulse | output | 16 | One-cycle trigger-set pulses |
| ch_abort_pulse | output | 16 | One-cycle abort pulses |
| ch_active | input | 16 | Channels with a transfer in progress |
| ch_busy | input | 16 | Channels with work in the internal pipeline |
| ch_err_evt | input | 16 | Error events from the engines |
| ch_inta_evt | input | 16 | Completion events for flag A |
| ch_intb_evt | input | 16 | Completion events for flag B |
| irq | output | 1 | Level interrupt, OR of both summary bits |

## Verification
The bench aims a flag-clearing write at the same cycle as a new error event on that channel. A design that let the clear win would lose the event and never raise the interrupt.

It clears flags with zero data and with partial masks. A design that treats the flag address as a plain store would wipe or overwrite unrelated flags.

It raises flags on channels whose interrupt is disabled, and on channels where only flag B is pending. This catches a summary that ignores the interrupt-enable mask or drops one flag set.

It turns the global enable off with channels enabled and issues a command while off. This exposes enables or pulses that leak through, and an enable mask lost across the off period.

// File: rtl/dmac_bank_pkg.sv
// Package: register word addresses and summary bit positions shared by the
// control bank, its checker and its bench. Assumes a word-addressed bus.
package dmac_bank_pkg;
    localparam int unsigned A_CTRL     = 0;
    localparam int unsigned A_SUMMARY  = 1;
    localparam int unsigned A_EN_SET   = 2;
    localparam int unsigned A_EN_CLR   = 3;
    localparam int unsigned A_ACTIVE   = 4;
    localparam int unsigned A_BUSY     = 5;
    localparam int unsigned A_ERR      = 6;
    localparam int unsigned A_IEN_SET  = 7;
    localparam int unsigned A_IEN_CLR  = 8;
    localparam int unsigned A_FLAGA    = 9;
    localparam int unsigned A_FLAGB    = 10;
    localparam int unsigned A_VALID    = 11;
    localparam int unsigned A_TRIG     = 12;
    localparam int unsigned A_ABORT    = 13;

    localparam int unsigned NUM_FLAGS  = 3;
    localparam int unsigned NUM_PULSES = 3;
    localparam int unsigned SUM_INT_BIT = 1;
    localparam int unsigned SUM_ERR_BIT = 2;

    // Flag set k: 0 error, 1 completion A, 2 completion B.
    function automatic int unsigned flag_addr(input int unsigned k);
        case (k)
            0:       return A_ERR;
            1:       return A_FLAGA;
            default: return A_FLAGB;
        endcase
    endfunction

    // Pulse group k: 0 valid, 1 trigger, 2 abort.
    function automatic int unsigned pulse_addr(input int unsigned k);
        case (k)
            0:       return A_VALID;
            1:       return A_TRIG;
            default: return A_ABORT;
        endcase
    endfunction
endpackage

// File: rtl/dmac_mask_pair.sv
// Module: mask register written through separate set and clear strobes.
// Assumes set and clear strobes come from distinct addresses; if both are
// ever high together, set wins.
module dmac_mask_pair #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mask_q
);
    logic [W-1:0] set_bits;
    logic [W-1:0] clr_bits;

    // Qualify write data with the strobes.
    always_comb begin
        set_bits = set_we ? wdata : '0;
        clr_bits = clr_we ? wdata : '0;
    end

    // Mask update: clear selected bits, then set selected bits.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= (mask_q & ~clr_bits) | set_bits;
    end
endmodule

// File: rtl/dmac_w1c_flags.sv
// Module: sticky flags set by engine events and cleared by write-one.
// Assumes events are one-cycle pulses; an event in the same cycle as a
// clear of that bit keeps the bit set so no event is lost.
module dmac_w1c_flags #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] evt,
    output logic [W-1:0] flags_q
);
    logic [W-1:0] clr_bits;

    // Bits the bus asks to clear this cycle.
    always_comb clr_bits = clr_we ? wdata : '0;

    // Flag update with the event taking priority over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~clr_bits) | evt;
    end
endmodule

// File: rtl/dmac_pulse_gen.sv
// Module: turns a command write into a one-cycle pulse on selected channels.
// Assumes the caller qualifies fire with the global enable.
module dmac_pulse_gen #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fire,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] pulse_q
);
    // Register the pulse for exactly the cycle after the write.
    always_ff @(posedge clk) begin
        if (!rst_n)    pulse_q <= '0;
        else if (fire) pulse_q <= wdata;
        else           pulse_q <= '0;
    end
endmodule

// File: rtl/dmac_ctrl_bank.sv
// Module: shared control and status register bank of a multi-channel DMA
// controller. Decodes single-cycle writes, reads combinationally, keeps
// enable and interrupt masks and sticky flags, and drives per-channel
// command pulses. Assumes NCH < DATA_W and a word-addressed bus.
module dmac_ctrl_bank
    import dmac_bank_pkg::*;
#(
    parameter int unsigned NCH    = 16,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wen,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [NCH-1:0]    ch_enable,
    output logic [NCH-1:0]    ch_valid_pulse,
    output logic [NCH-1:0]    ch_trig_pulse,
    output logic [NCH-1:0]    ch_abort_pulse,
    input  logic [NCH-1:0]    ch_active,
    input  logic [NCH-1:0]    ch_busy,
    input  logic [NCH-1:0]    ch_err_evt,
    input  logic [NCH-1:0]    ch_inta_evt,
    input  logic [NCH-1:0]    ch_intb_evt,
    output logic              irq
);
    localparam int unsigned NREG = 2 ** ADDR_W;

    logic [NREG-1:0]               wr_hit;
    logic [NCH-1:0]                wr_mask;
    logic                          ctrl_en_q;
    logic [NCH-1:0]                en_q;
    logic [NCH-1:0]                ien_q;
    logic [NUM_FLAGS-1:0][NCH-1:0] flag_evt;
    logic [NUM_FLAGS-1:0][NCH-1:0] flag_q;
    logic [NUM_PULSES-1:0][NCH-1:0] pulse_q;
    logic [NCH-1:0]                err_q;
    logic [NCH-1:0]                inta_q;
    logic [NCH-1:0]                intb_q;
    logic                          sum_int;
    logic                          sum_err;
    logic [DATA_W-1:0]             summary_word;
    logic                          unused_wdata;

    // One-hot write decode per register word.
    always_comb begin
        for (int k = 0; k < NREG; k++) begin
            wr_hit[k] = reg_wen && (reg_addr == ADDR_W'(k));
        end
    end

    // Channel slice of the write data; upper bits feed no register.
    always_comb wr_mask = reg_wdata[NCH-1:0];
    assign unused_wdata = ^reg_wdata[DATA_W-1:NCH];

    // Global controller enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n)               ctrl_en_q <= 1'b0;
        else if (wr_hit[A_CTRL])  ctrl_en_q <= reg_wdata[0];
    end

    dmac_mask_pair #(.W(NCH)) u_en_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_we (wr_hit[A_EN_SET]),
        .clr_we (wr_hit[A_EN_CLR]),
        .wdata  (wr_mask),
        .mask_q (en_q)
    );

    dmac_mask_pair #(.W(NCH)) u_ien_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_we (wr_hit[A_IEN_SET]),
        .clr_we (wr_hit[A_IEN_CLR]),
        .wdata  (wr_mask),
        .mask_q (ien_q)
    );

    // Route engine events to the matching flag set.
    always_comb begin
        flag_evt[0] = ch_err_evt;
        flag_evt[1] = ch_inta_evt;
        flag_evt[2] = ch_intb_evt;
    end

    for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flags
        dmac_w1c_flags #(.W(NCH)) u_flags (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr_we  (wr_hit[flag_addr(f)]),
            .wdata   (wr_mask),
            .evt     (flag_evt[f]),
            .flags_q (flag_q[f])
        );
    end

    for (genvar p = 0; p < NUM_PULSES; p++) begin : g_pulses
        dmac_pulse_gen #(.W(NCH)) u_pulse (
            .clk     (clk),
            .rst_n   (rst_n),
            .fire    (wr_hit[pulse_addr(p)] && ctrl_en_q),
            .wdata   (wr_mask),
            .pulse_q (pulse_q[p])
        );
    end

    // Name the flag sets and pulse groups for readability.
    always_comb begin
        err_q          = flag_q[0];
        inta_q         = flag_q[1];
        intb_q         = flag_q[2];
        ch_valid_pulse = pulse_q[0];
        ch_trig_pulse  = pulse_q[1];
        ch_abort_pulse = pulse_q[2];
    end

    // Channel enables reach the engines only under the global enable.
    always_comb ch_enable = ctrl_en_q ? en_q : '0;

    // Summary word from interrupt-enabled channels only.
    always_comb begin
        sum_int      = |((inta_q | intb_q) & ien_q);
        sum_err      = |(err_q & ien_q);
        summary_word = '0;
        summary_word[SUM_INT_BIT] = sum_int;
        summary_word[SUM_ERR_BIT] = sum_err;
    end

    // Level interrupt output.
    always_comb irq = sum_int | sum_err;

    // Combinational read mux; write-only and unused words read zero.
    always_comb begin
        reg_rdata = '0;
        case (int'(reg_addr))
            A_CTRL:    reg_rdata[0] = ctrl_en_q;
            A_SUMMARY: reg_rdata = summary_word;
            A_EN_SET:  reg_rdata[NCH-1:0] = en_q;
            A_ACTIVE:  reg_rdata[NCH-1:0] = ch_active;
            A_BUSY:    reg_rdata[NCH-1:0] = ch_busy;
            A_ERR:     reg_rdata[NCH-1:0] = err_q;
            A_IEN_SET: reg_rdata[NCH-1:0] = ien_q;
            A_FLAGA:   reg_rdata[NCH-1:0] = inta_q;
            A_FLAGB:   reg_rdata[NCH-1:0] = intb_q;
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dmac_ctrl_bank_chk.sv
// Checker: temporal properties of the control bank, bound to the top module.
// Assumes the same parameters as the bound instance.
module dmac_ctrl_bank_chk
    import dmac_bank_pkg::*;
#(
    parameter int unsigned NCH    = 16,
    parameter int unsigned ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wen,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [NCH-1:0]    wr_mask,
    input logic              ctrl_en_q,
    input logic [NCH-1:0]    en_q,
    input logic [NCH-1:0]    ien_q,
    input logic [NCH-1:0]    err_q,
    input logic [NCH-1:0]    inta_q,
    input logic [NCH-1:0]    intb_q,
    input logic [NCH-1:0]    ch_enable,
    input logic [NCH-1:0]    ch_trig_pulse,
    input logic [NCH-1:0]    ch_err_evt,
    input logic              irq
);
    // R2: a clear write leaves none of the written bits set.
    assert_en_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wen && reg_addr == ADDR_W'(A_EN_CLR)) |=> ((en_q & $past(wr_mask)) == '0));

    // R3: global enable off gates all channel enables.
    assert_global_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en_q |-> (ch_enable == '0));

    // R6: an error event is always captured, even against a clear.
    assert_event_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_err_evt) |=> ((err_q & $past(ch_err_evt)) == $past(ch_err_evt)));

    // R9: a trigger pulse follows a trigger write made while enabled.
    assert_trig_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_trig_pulse) |-> $past(reg_wen && reg_addr == ADDR_W'(A_TRIG) && ctrl_en_q));

    // R11: irq tracks the enabled pending flags.
    assert_irq_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (|((inta_q | intb_q | err_q) & ien_q)));
endmodule

bind dmac_ctrl_bank dmac_ctrl_bank_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_wen       (reg_wen),
    .reg_addr      (reg_addr),
    .wr_mask       (wr_mask),
    .ctrl_en_q     (ctrl_en_q),
    .en_q          (en_q),
    .ien_q         (ien_q),
    .err_q         (err_q),
    .inta_q        (inta_q),
    .intb_q        (intb_q),
    .ch_enable     (ch_enable),
    .ch_trig_pulse (ch_trig_pulse),
    .ch_err_evt    (ch_err_evt),
    .irq           (irq)
);

// File: tb/tb_dmac_ctrl_bank.sv
`timescale 1ns/1ps
module tb_dmac_ctrl_bank;
    localparam int NCH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wen = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NCH-1:0] ch_enable, ch_valid_pulse, ch_trig_pulse, ch_abort_pulse;
    logic [NCH-1:0] ch_active = '0, ch_busy = '0;
    logic [NCH-1:0] ch_err_evt = '0, ch_inta_evt = '0, ch_intb_evt = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dmac_ctrl_bank dut (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ch_enable(ch_enable),
        .ch_valid_pulse(ch_valid_pulse), .ch_trig_pulse(ch_trig_pulse),
        .ch_abort_pulse(ch_abort_pulse), .ch_active(ch_active), .ch_busy(ch_busy),
        .ch_err_evt(ch_err_evt), .ch_inta_evt(ch_inta_evt), .ch_intb_evt(ch_intb_evt),
        .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = 4'(a); reg_wdata = d;
        @(negedge clk);
        reg_wen = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd_chk(input string req, input int a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = 4'(a);
        #1 chk(req, reg_rdata, exp);
    endtask

    task automatic fire_evt(input logic [NCH-1:0] e, input logic [NCH-1:0] a, input logic [NCH-1:0] b);
        @(negedge clk);
        ch_err_evt = e; ch_inta_evt = a; ch_intb_evt = b;
        @(negedge clk);
        ch_err_evt = '0; ch_inta_evt = '0; ch_intb_evt = '0;
    endtask

    // Command write; pulses checked in the cycle after the write, then idle.
    task automatic cmd_chk(input string req, input int a, input logic [31:0] d,
                           input logic [NCH-1:0] ev, input logic [NCH-1:0] et,
                           input logic [NCH-1:0] eab);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = 4'(a); reg_wdata = d;
        @(posedge clk); #1;
        chk({req, " valid"}, 32'(ch_valid_pulse), 32'(ev));
        chk({req, " trig"},  32'(ch_trig_pulse),  32'(et));
        chk({req, " abort"}, 32'(ch_abort_pulse), 32'(eab));
        @(negedge clk);
        reg_wen = 1'b0; reg_wdata = '0;
        @(posedge clk); #1;
        chk({req, " pulse width"}, 32'(ch_valid_pulse | ch_trig_pulse | ch_abort_pulse), 32'h0);
    endtask

    task automatic t_reset();
        for (int a = 0; a < 16; a++) rd_chk("R12 reset read", a, 32'h0);
        chk("R12 reset enables", 32'(ch_enable), 32'h0);
        chk("R12 reset irq", 32'(irq), 32'h0);
    endtask

    task automatic t_enable();
        wr(0, 32'h1);
        rd_chk("R3 ctrl readback", 0, 32'h1);
        wr(2, 32'h8001);
        rd_chk("R1 R2 set mask", 2, 32'h8001);
        chk("R1 enable port bits", 32'(ch_enable), 32'h8001);
        wr(2, 32'h0010);
        rd_chk("R2 set accumulates", 2, 32'h8011);
        wr(3, 32'h8000);
        rd_chk("R2 clear one bit", 2, 32'h0011);
        chk("R2 enable port after clear", 32'(ch_enable), 32'h0011);
        rd_chk("R10 enable clear reads zero", 3, 32'h0);
        rd_chk("R10 trigger addr reads zero", 12, 32'h0);
        rd_chk("R10 unused addr reads zero", 15, 32'h0);
    endtask

    task automatic t_global();
        wr(0, 32'h0);
        rd_chk("R3 ctrl off", 0, 32'h0);
        chk("R3 enables gated", 32'(ch_enable), 32'h0);
        rd_chk("R3 mask kept", 2, 32'h0011);
        cmd_chk("R3 no pulse when off", 11, 32'h3, '0, '0, '0);
        wr(0, 32'h1);
        #1 chk("R3 enables restored", 32'(ch_enable), 32'h0011);
    endtask

    task automatic t_flags();
        fire_evt(16'h0008, '0, '0);
        rd_chk("R5 error flag set", 6, 32'h8);
        rd_chk("R4 disabled channel no summary", 1, 32'h0);
        chk("R4 irq low when disabled", 32'(irq), 32'h0);
        wr(7, 32'h8);
        rd_chk("R4 ien readback", 7, 32'h8);
        rd_chk("R7 summary error bit", 1, 32'h4);
        chk("R11 irq on error", 32'(irq), 32'h1);
        wr(6, 32'h0);
        rd_chk("R5 zero write keeps flag", 6, 32'h8);
        wr(6, 32'h8);
        rd_chk("R5 w1c clears error", 6, 32'h0);
        chk("R11 irq drops", 32'(irq), 32'h0);
        fire_evt('0, 16'h0020, '0);
        rd_chk("R5 flag A set", 9, 32'h20);
        wr(7, 32'h20);
        rd_chk("R7 summary int bit", 1, 32'h2);
        chk("R11 irq on flag A", 32'(irq), 32'h1);
        fire_evt('0, '0, 16'h0040);
        rd_chk("R5 flag B set", 10, 32'h40);
        wr(9, 32'h20);
        rd_chk("R5 flag A cleared", 9, 32'h0);
        rd_chk("R4 flag B unenabled no summary", 1, 32'h0);
        chk("R11 irq low", 32'(irq), 32'h0);
        wr(7, 32'h40);
        rd_chk("R7 flag B counts when enabled", 1, 32'h2);
        wr(8, 32'h68);
        rd_chk("R4 ien cleared", 7, 32'h0);
        rd_chk("R4 summary off after ien clear", 1, 32'h0);
        wr(10, 32'h40);
        rd_chk("R5 flag B cleared", 10, 32'h0);
    endtask

    task automatic t_collide();
        fire_evt(16'h0006, '0, '0);
        rd_chk("R5 two error flags", 6, 32'h6);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = 4'd6; reg_wdata = 32'h6; ch_err_evt = 16'h0004;
        @(negedge clk);
        reg_wen = 1'b0; reg_wdata = '0; ch_err_evt = '0;
        rd_chk("R6 set wins over clear", 6, 32'h4);
        wr(6, 32'h4);
        rd_chk("R6 later clear works", 6, 32'h0);
    endtask

    task automatic t_pulses();
        cmd_chk("R9 trigger pulse", 12, 32'h00A0, '0, 16'h00A0, '0);
        cmd_chk("R9 abort pulse", 13, 32'h0001, '0, '0, 16'h0001);
        cmd_chk("R9 R1 valid pulse top channel", 11, 32'h8000, 16'h8000, '0, '0);
    endtask

    task automatic t_status();
        @(negedge clk);
        ch_active = 16'h1234; ch_busy = 16'hF000;
        rd_chk("R8 active mask", 4, 32'h1234);
        rd_chk("R8 busy mask", 5, 32'hF000);
        wr(4, 32'hFFFF);
        wr(5, 32'h0);
        wr(1, 32'hFFFF);
        rd_chk("R8 active write ignored", 4, 32'h1234);
        rd_chk("R8 busy write ignored", 5, 32'hF000);
        rd_chk("R8 summary write ignored", 1, 32'h0);
        chk("R8 irq unaffected", 32'(irq), 32'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_enable();
        t_global();
        t_flags();
        t_collide();
        t_pulses();
        t_status();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule